// File: doc/BRIEF.md
# Fractional Predivider Clock Generator

The block derives a peripheral clock, such as a pixel clock or an audio master clock, from one of three free-running source clocks: a crystal reference and two PLL outputs. A predivider with ratios 2, 2.5 or 3 is followed by an integer divider, so the output period is (P+3)·D half-periods of the chosen source. P is the 2-bit predivider code and D is the 7-bit divider value. Both edges of the source clock advance one shared phase count. Its result is recombined by XOR-ing two toggle flops, one on each edge, so the 2.5 ratio and any odd half-period count need no analog help.

Choosing P and D for a target frequency is left to the software that drives the block. It writes the source select, P, D and an enable. It reads back a valid flag, which tells it whether the current setting can produce a clock at all. A predivider code of 0 or a divider below 2 stops the clock, and so does a clear enable. P=1 with D=2 is the safe setting to load before first use.

A source switch is break-before-make. The output is first forced low on the old clock, then the old clock is removed, then the new clock is gated in, and only after that does the divider restart.

Top module: `frac_clkgen`

## Requirements
- R1: With predivider code P in {1,2,3} and divider D in 2..127, every output period lasts exactly H=(P+3)·D half-periods of the selected source.
- R2: Each output high phase lasts floor(H/2) source half-periods and the low phase lasts the rest, so an odd H places one edge on a falling source edge.
- R3: Predivider code 0 stops the output: clk_o stays low with no rising edge, and valid_o is 0.
- R4: A divider value of 0 or 1 stops the output in the same way, and valid_o is 0.
- R5: When en_i is 0, clk_o stays low and valid_o is 0. valid_o is 1 exactly when en_i=1, P≠0 and D≥2, and it follows these inputs combinationally.
- R6: The source is chosen as follows: ext_sel_i=0 picks clk_ref_i; ext_sel_i=1 with pll_sel_i=0 picks clk_pll_a_i; ext_sel_i=1 with pll_sel_i=1 picks clk_pll_b_i.
- R7: A source change while running gives no output pulse shorter than one half-period of the old source. The low gap around the change lasts at least one full period of the old source plus one full period of the new source. At most one source is gated into the divider at any time.
- R8: P and D are captured only while the output is stopped. A change made while running has no effect until the output is stopped and restarted through en_i.
- R9: While rst_ni is low, clk_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low asynchronous reset |
| clk_ref_i | input | 1 | Crystal reference source clock |
| clk_pll_a_i | input | 1 | First PLL source clock |
| clk_pll_b_i | input | 1 | Second PLL source clock |
| ext_sel_i | input | 1 | 0: reference source; 1: one of the PLLs |
| pll_sel_i | input | 1 | PLL choice when ext_sel_i is 1 (0: A, 1: B) |
| pdiv_i | input | 2 | Predivider code: 0 off, 1/2/3 give ratio 2/2.5/3 |
| div_i | input | 7 | Integer divider, valid 2..127 |
| en_i | input | 1 | Output enable |
| clk_o | output | 1 | Generated clock |
| valid_o | output | 1 | Setting and enable allow a running clock |

## Verification
valid_o is combinational, so the bench samples it one nanosecond after it changes an input. Stopping clk_o takes effect at the third edge of the active source after the request, because the request passes a two-flop synchronizer. The bench therefore waits at least 100 ns before it checks that the output is quiet. Starting up takes the switch chain plus the synchronizer, which is several source cycles. For that reason every period and high-phase measurement discards the first rising edge after a change and times the next full cycle from edge timestamps. For a source switch, the bench timestamps the last falling edge and the first new rising edge, and requires that gap to be at least one old period plus one new period.

// File: rtl/fpcg_pkg.sv
package fpcg_pkg;

  typedef enum logic [1:0] {
    SRC_REF   = 2'd0,
    SRC_PLL_A = 2'd1,
    SRC_PLL_B = 2'd2
  } src_e;

  function automatic src_e src_index(input logic ext_sel, input logic pll_sel);
    if (!ext_sel) return SRC_REF;
    return pll_sel ? SRC_PLL_B : SRC_PLL_A;
  endfunction

endpackage

// File: rtl/fpcg_sync.sv
module fpcg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], d_i};
  end

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/fpcg_src_switch.sv
module fpcg_src_switch #(
  parameter int N_SRC     = 3,
  parameter int SW_STAGES = 4,
  localparam int IDX_W    = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] clk_src_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] sel_i,
  output logic [N_SRC-1:0] live_o,
  output logic             clk_o
);
  logic [N_SRC-1:0] busy;
  logic [N_SRC-1:0] gated;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic [SW_STAGES-1:0] chain_q;
    logic                 en_q;
    logic                 req;

    // request only once every other path has fully drained
    always_comb req = (sel_i == IDX_W'(i)) &&
                      ((busy & ~(N_SRC'(1) << i)) == '0);

    always_ff @(posedge clk_src_i[i] or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[SW_STAGES-2:0], req};
    end

    // enable moves only while this source is low
    always_ff @(negedge clk_src_i[i] or negedge rst_ni) begin
      if (!rst_ni) en_q <= 1'b0;
      else         en_q <= chain_q[SW_STAGES-1];
    end

    assign busy[i]   = (|chain_q) | en_q;
    assign live_o[i] = en_q;
    assign gated[i]  = clk_src_i[i] & en_q;

    AST_ONE_SOURCE: assert property (@(posedge clk_src_i[i]) disable iff (!rst_ni)
      $onehot0(live_o)) else $error("two sources gated at once"); // R7
  end

  assign clk_o = |gated;
endmodule

// File: rtl/fpcg_halfcycle_div.sv
module fpcg_halfcycle_div #(
  parameter int DIV_W  = 7,
  parameter int PDIV_W = 2,
  localparam int CNT_W = DIV_W + PDIV_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [PDIV_W-1:0] pdiv_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic              clk_o
);
  logic [PDIV_W-1:0] pdiv_q;
  logic [DIV_W-1:0]  div_q;
  logic [CNT_W-1:0]  span, half, last;
  logic [CNT_W-1:0]  pos_t, neg_t, pos_nt, neg_nt;
  logic              pos_q, neg_q;

  // settings are captured only while stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pdiv_q <= PDIV_W'(1);
      div_q  <= DIV_W'(2);
    end else if (!run_i) begin
      pdiv_q <= pdiv_i;
      div_q  <= div_i;
    end
  end

  // span in source half-periods: (code+3)*div
  assign span = (CNT_W'(pdiv_q) + CNT_W'(3)) * CNT_W'(div_q);
  assign half = span >> 1;
  assign last = span - CNT_W'(1);

  assign pos_nt = (neg_t >= last) ? '0 : neg_t + CNT_W'(1);
  assign neg_nt = (pos_t >= last) ? '0 : pos_t + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_t <= '0;
      pos_q <= 1'b0;
    end else if (!run_i) begin
      pos_t <= last;
      pos_q <= neg_q;
    end else begin
      pos_t <= pos_nt;
      if (pos_nt == '0 || pos_nt == half) pos_q <= ~pos_q;
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      neg_t <= '0;
      neg_q <= 1'b0;
    end else if (!run_i) begin
      neg_t <= last;
    end else begin
      neg_t <= neg_nt;
      if (neg_nt == '0 || neg_nt == half) neg_q <= ~neg_q;
    end
  end

  // only one toggle flop changes per edge
  assign clk_o = pos_q ^ neg_q;

  function automatic logic [CNT_W-1:0] adv2(input logic [CNT_W-1:0] t,
                                            input logic [CNT_W-1:0] s);
    logic [CNT_W:0] a;
    a = {1'b0, t} + (CNT_W+1)'(2);
    if (a >= {1'b0, s}) a = a - {1'b0, s};
    return a[CNT_W-1:0];
  endfunction

  AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_i) && $past(run_i, 2)) |-> (pos_t == adv2($past(pos_t), span)))
    else $error("phase advance broken"); // R1

  AST_HELD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && $past(!run_i)) |-> !clk_o) else $error("output not low while held"); // R5

  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(run_i) |-> ($stable(div_q) && $stable(pdiv_q)))
    else $error("settings changed while running"); // R8
endmodule

// File: rtl/frac_clkgen.sv
module frac_clkgen #(
  parameter int DIV_W       = 7,
  parameter int PDIV_W      = 2,
  parameter int MIN_DIV     = 2,
  parameter int SYNC_STAGES = 2,
  parameter int SW_STAGES   = 4
) (
  input  logic              rst_ni,
  input  logic              clk_ref_i,
  input  logic              clk_pll_a_i,
  input  logic              clk_pll_b_i,
  input  logic              ext_sel_i,
  input  logic              pll_sel_i,
  input  logic [PDIV_W-1:0] pdiv_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              en_i,
  output logic              clk_o,
  output logic              valid_o
);
  import fpcg_pkg::*;

  localparam int N_SRC = 3;

  src_e             sel_idx;
  logic [N_SRC-1:0] live;
  logic             mux_clk;
  logic             run_req;
  logic             run;

  assign sel_idx = src_index(ext_sel_i, pll_sel_i);
  assign valid_o = en_i && (pdiv_i != '0) && (div_i >= DIV_W'(MIN_DIV));
  // hold while the wanted source is not yet the gated one
  assign run_req = valid_o && live[sel_idx];

  fpcg_src_switch #(
    .N_SRC    (N_SRC),
    .SW_STAGES(SW_STAGES)
  ) u_switch (
    .clk_src_i({clk_pll_b_i, clk_pll_a_i, clk_ref_i}),
    .rst_ni   (rst_ni),
    .sel_i    (sel_idx),
    .live_o   (live),
    .clk_o    (mux_clk)
  );

  fpcg_sync #(.STAGES(SYNC_STAGES)) u_run_sync (
    .clk_i (mux_clk),
    .rst_ni(rst_ni),
    .d_i   (run_req),
    .q_o   (run)
  );

  fpcg_halfcycle_div #(
    .DIV_W (DIV_W),
    .PDIV_W(PDIV_W)
  ) u_div (
    .clk_i (mux_clk),
    .rst_ni(rst_ni),
    .run_i (run),
    .pdiv_i(pdiv_i),
    .div_i (div_i),
    .clk_o (clk_o)
  );
endmodule

// File: tb/frac_clkgen_bench.sv
module frac_clkgen_bench;
  timeunit 1ns;
  timeprecision 1ps;

  logic rst_ni = 1'b0;
  logic clk_ref = 1'b0, clk_pa = 1'b0, clk_pb = 1'b0;
  logic ext_sel = 1'b0, pll_sel = 1'b0, en = 1'b0;
  logic [1:0] pdiv = 2'd1;
  logic [6:0] div = 7'd2;
  logic clk_o, valid_o;

  int  checks = 0, errors = 0;
  int  rise_cnt = 0, fall_cnt = 0;
  real t_rise = 0.0, t_fall = 0.0;

  always #4   clk_ref = ~clk_ref;  // 125 MHz
  always #3   clk_pa  = ~clk_pa;
  always #2.5 clk_pb  = ~clk_pb;

  frac_clkgen u_frac_clkgen (
    .rst_ni(rst_ni), .clk_ref_i(clk_ref), .clk_pll_a_i(clk_pa), .clk_pll_b_i(clk_pb),
    .ext_sel_i(ext_sel), .pll_sel_i(pll_sel), .pdiv_i(pdiv), .div_i(div),
    .en_i(en), .clk_o(clk_o), .valid_o(valid_o)
  );

  always @(posedge clk_o) begin rise_cnt++; t_rise = $realtime; end
  always @(negedge clk_o) begin fall_cnt++; t_fall = $realtime; end

  function automatic real half_ns(input int s);
    return (s == 0) ? 4.0 : (s == 1) ? 3.0 : 2.5;
  endfunction
  function automatic real exp_per(input int s, input int p, input int d);
    return real'((p + 3) * d) * half_ns(s);
  endfunction
  function automatic real exp_hi(input int s, input int p, input int d);
    return real'(((p + 3) * d) / 2) * half_ns(s);
  endfunction
  function automatic real rabs(input real x);
    return (x < 0.0) ? -x : x;
  endfunction

  task automatic chk(input bit ok, input string req, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  task automatic wait_rise(output bit ok);
    int c = rise_cnt;
    ok = 1'b0;
    for (int k = 0; k < 40000; k++) begin
      if (rise_cnt != c) begin ok = 1'b1; break; end
      #0.5;
    end
  endtask

  task automatic wait_fall(output bit ok);
    int c = fall_cnt;
    ok = 1'b0;
    for (int k = 0; k < 40000; k++) begin
      if (fall_cnt != c) begin ok = 1'b1; break; end
      #0.5;
    end
  endtask

  task automatic set_src(input int s);
    ext_sel = (s != 0);
    pll_sel = (s == 2);
  endtask

  task automatic configure(input int s, input int p, input int d);
    en = 1'b0;
    #100;
    set_src(s);
    pdiv = 2'(p);
    div  = 7'(d);
    #300;
    en = 1'b1;
    #1;
  endtask

  task automatic meas(input int s, input int p, input int d, input string req);
    bit ok, all;
    real t0, t1, t2;
    all = 1'b1;
    wait_rise(ok); all &= ok;
    wait_rise(ok); all &= ok; t0 = t_rise;
    wait_fall(ok); all &= ok; t1 = t_fall;
    wait_rise(ok); all &= ok; t2 = t_rise;
    chk(all && rabs((t2 - t0) - exp_per(s, p, d)) < 0.01, req,
        $sformatf("period src%0d p%0d d%0d actual %0.3f expected %0.3f",
                  s, p, d, t2 - t0, exp_per(s, p, d)));
    chk(all && rabs((t1 - t0) - exp_hi(s, p, d)) < 0.01, "R2",
        $sformatf("high src%0d p%0d d%0d actual %0.3f expected %0.3f",
                  s, p, d, t1 - t0, exp_hi(s, p, d)));
  endtask

  task automatic expect_quiet(input string req);
    int c = rise_cnt;
    #2000;
    chk(rise_cnt == c && clk_o == 1'b0, req,
        $sformatf("rises actual %0d expected 0, clk_o actual %0b expected 0",
                  rise_cnt - c, clk_o));
  endtask

  initial begin
    #1_500_000;
    chk(1'b0, "watchdog", "timeout actual expired expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit ok;
    real tr0, gap, pulse;
    void'($urandom(32'h5EED));

    // R9: reset holds output low even with a valid setting
    en = 1'b1;
    #20;
    chk(clk_o == 1'b0, "R9", $sformatf("clk_o in reset actual %0b expected 0", clk_o));
    en = 1'b0;
    #1;
    chk(valid_o == 1'b0, "R5", $sformatf("valid_o actual %0b expected 0", valid_o));
    #30;
    rst_ni = 1'b1;

    // R1/R2 directed, even and odd half-period counts
    configure(0, 1, 2);
    chk(valid_o == 1'b1, "R5", $sformatf("valid_o actual %0b expected 1", valid_o));
    meas(0, 1, 2, "R1");
    configure(0, 2, 3);
    meas(0, 2, 3, "R1");
    configure(1, 3, 127);
    meas(1, 3, 127, "R1");

    // R6: same setting on each source
    configure(0, 2, 5);
    meas(0, 2, 5, "R6");
    configure(1, 2, 5);
    meas(1, 2, 5, "R6");
    configure(2, 2, 5);
    meas(2, 2, 5, "R6");

    // R3: predivider code 0
    configure(0, 0, 4);
    chk(valid_o == 1'b0, "R3", $sformatf("valid_o actual %0b expected 0", valid_o));
    expect_quiet("R3");

    // R4: divider 1 and 0
    configure(1, 1, 1);
    chk(valid_o == 1'b0, "R4", $sformatf("valid_o actual %0b expected 0", valid_o));
    expect_quiet("R4");
    configure(2, 3, 0);
    chk(valid_o == 1'b0, "R4", $sformatf("valid_o actual %0b expected 0", valid_o));
    expect_quiet("R4");

    // R5: enable cleared while running
    configure(0, 1, 2);
    wait_rise(ok);
    en = 1'b0;
    #1;
    chk(valid_o == 1'b0, "R5", $sformatf("valid_o actual %0b expected 0", valid_o));
    #100;
    expect_quiet("R5");

    // R8: divider change while running is ignored until restart
    configure(1, 1, 3);
    meas(1, 1, 3, "R8");
    div = 7'd9;
    #1;
    chk(valid_o == 1'b1, "R5", $sformatf("valid_o actual %0b expected 1", valid_o));
    meas(1, 1, 3, "R8");
    en = 1'b0;
    #100;
    en = 1'b1;
    meas(1, 1, 9, "R8");

    // R7: switch reference to PLL B while running
    configure(0, 3, 20);
    wait_rise(ok);
    tr0 = t_rise;
    #10;
    set_src(2);
    wait_rise(ok);
    gap   = t_rise - t_fall;
    pulse = t_fall - tr0;
    chk(ok && gap >= 13.0, "R7", $sformatf("low gap actual %0.3f expected >= 13.000", gap));
    chk(ok && pulse >= 4.0, "R7", $sformatf("cut pulse actual %0.3f expected >= 4.000", pulse));
    meas(2, 3, 20, "R7");

    // R1: random settings
    for (int n = 0; n < 10; n++) begin
      int s, p, d;
      s = $urandom_range(0, 2);
      p = $urandom_range(1, 3);
      d = $urandom_range(2, 127);
      configure(s, p, d);
      chk(valid_o == 1'b1, "R5", $sformatf("valid_o actual %0b expected 1", valid_o));
      meas(s, p, d, "R1");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule